// File: doc/BRIEF.md
# Host Address Window Decoder

This block decides whether a host I/O or memory cycle belongs to a downstream peripheral link. Software programs a set of generic I/O windows, a set of generic memory windows and three fixed legacy I/O decodes through a small register port. One shared enable register gates all of them, and a control register holds a bus-master gate and a fallback-claim mode.

A purely combinational lookup port takes a cycle type and an address. It returns whether the cycle is claimed, which decode claimed it, and whether it was taken only because the fallback mode claims every cycle that no decode matches. Moving the cycle onto the link is left to other logic.

Top module: `haddr_window_decoder`

## Requirements
- R1: After reset every register reads zero, and no lookup reports a hit or a fallback claim.
- R2: The register port reads back the implemented bits and returns zero in unused bits. Enable register at 0x00: bit 0 = port 0x80, bit 1 = ports 0x60/0x64, bit 2 = ports 0x2E/0x2F, bit 8+i = I/O window i, bit 16+j = memory window j. Control register at 0x04: bit 1 = bus-master gate, bit 2 = fallback mode, bits 4:3 = fallback target. I/O window i at 0x40+4i holds base in bits 15:0 and stored size in bits 23:16. Memory window j holds its base at 0x80+8j and its 16-bit stored size at 0x84+8j.
- R3: An enabled I/O window matches an I/O cycle whose port (address bits 15:0) lies from base to base+stored size inclusive, so a stored size of 0 covers one port. Address bits 31:16 are ignored for I/O cycles.
- R4: An enabled memory window matches a memory cycle whose 32-bit address lies from base to base+stored size inclusive.
- R5: Each fixed decode matches only I/O cycles, and only while its own enable bit is set. The decodes are port 0x80; ports 0x60 and 0x64 (not 0x61 to 0x63) under one bit; ports 0x2E and 0x2F under one bit.
- R6: On a hit the index is 0, 1 or 2 for the fixed decodes in the order above, 3+i for I/O window i and 3+N+j for memory window j (N = number of I/O windows). Fixed decodes take priority over windows, and among windows the lowest number wins. On a miss the index is 0.
- R7: A window range never wraps past the top of its address space. A window placed near the top covers only up to the highest address.
- R8: Writing zero to the enable register stops every window and every fixed decode from matching, starting in the next cycle.
- R9: While the bus-master gate is clear, no hit and no fallback claim is reported.
- R10: With the bus-master gate and the fallback mode both set, a cycle that matches nothing sets the fallback flag and outputs the target field. A hit never sets the flag. When the flag is clear, the target output is 0.
- R11: I/O windows and fixed decodes never match memory cycles, and memory windows never match I/O cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_is_mem | input | 1 | Lookup cycle type: 1 = memory, 0 = I/O |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Cycle claimed by a decode |
| lk_index | output | IDXW | Index of the claiming decode |
| lk_sub | output | 1 | Cycle claimed only by fallback mode |
| lk_sub_tgt | output | 2 | Fallback target while lk_sub is set |

## Verification
A wrong base, size or enable bit shows at the lookup port in the same cycle. It appears as a hit, a miss or an index that differs from the arithmetic model, and often only at the first or last port of a window. Every I/O port is swept for each configuration, and memory addresses are probed at every window edge. Priority mistakes show only where decodes overlap, so the configurations place overlaps on purpose. A stale register shows one cycle after the write that should have changed it.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
   localparam int          IO_AW       = 16;
   localparam int          MEM_AW      = 32;
   localparam int          NUM_FIXED   = 3;
   localparam int          FIX_P80     = 0;
   localparam int          FIX_KBD     = 1;
   localparam int          FIX_SIO     = 2;
   localparam logic [7:0]  A_ENABLE    = 8'h00;
   localparam logic [7:0]  A_CTRL      = 8'h04;
   localparam logic [7:0]  A_IO_WIN    = 8'h40;
   localparam logic [7:0]  A_MEM_WIN   = 8'h80;
   localparam int          EN_IO_LSB   = 8;
   localparam int          EN_MEM_LSB  = 16;
   localparam int          CTRL_BM     = 1;
   localparam int          CTRL_SUB    = 2;
   localparam int          CTRL_TGT    = 3;
endpackage

// File: rtl/hwd_regs.sv
module hwd_regs
   import hwd_pkg::*;
#(
   parameter int IO_WINS    = 4,
   parameter int MEM_WINS   = 4,
   parameter int IO_SIZE_W  = 8,
   parameter int MEM_SIZE_W = 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   we,
   input  logic [7:0]                             addr,
   input  logic [31:0]                            wdata,
   output logic [31:0]                            rdata,
   output logic [NUM_FIXED-1:0]                   fixed_en,
   output logic [IO_WINS-1:0]                     io_en,
   output logic [MEM_WINS-1:0]                    mem_en,
   output logic [IO_WINS-1:0][IO_AW-1:0]          io_base,
   output logic [IO_WINS-1:0][IO_SIZE_W-1:0]      io_size,
   output logic [MEM_WINS-1:0][MEM_AW-1:0]        mem_base,
   output logic [MEM_WINS-1:0][MEM_SIZE_W-1:0]    mem_size,
   output logic                                   bm_en,
   output logic                                   sub_en,
   output logic [1:0]                             sub_tgt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fixed_en <= '0;
         io_en    <= '0;
         mem_en   <= '0;
         io_base  <= '0;
         io_size  <= '0;
         mem_base <= '0;
         mem_size <= '0;
         bm_en    <= 1'b0;
         sub_en   <= 1'b0;
         sub_tgt  <= 2'd0;
      end else if (we) begin
         if (addr == A_ENABLE) begin
            fixed_en <= wdata[NUM_FIXED-1:0];
            io_en    <= wdata[EN_IO_LSB +: IO_WINS];
            mem_en   <= wdata[EN_MEM_LSB +: MEM_WINS];
         end
         if (addr == A_CTRL) begin
            bm_en   <= wdata[CTRL_BM];
            sub_en  <= wdata[CTRL_SUB];
            sub_tgt <= wdata[CTRL_TGT +: 2];
         end
         for (int i = 0; i < IO_WINS; i++) begin
            if (addr == A_IO_WIN + 8'(4 * i)) begin
               io_base[i] <= wdata[IO_AW-1:0];
               io_size[i] <= wdata[16 +: IO_SIZE_W];
            end
         end
         for (int j = 0; j < MEM_WINS; j++) begin
            if (addr == A_MEM_WIN + 8'(8 * j))
               mem_base[j] <= wdata;
            if (addr == A_MEM_WIN + 8'(8 * j + 4))
               mem_size[j] <= wdata[MEM_SIZE_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_ENABLE) begin
         rdata[NUM_FIXED-1:0]           = fixed_en;
         rdata[EN_IO_LSB +: IO_WINS]    = io_en;
         rdata[EN_MEM_LSB +: MEM_WINS]  = mem_en;
      end
      if (addr == A_CTRL) begin
         rdata[CTRL_BM]       = bm_en;
         rdata[CTRL_SUB]      = sub_en;
         rdata[CTRL_TGT +: 2] = sub_tgt;
      end
      for (int i = 0; i < IO_WINS; i++) begin
         if (addr == A_IO_WIN + 8'(4 * i)) begin
            rdata[IO_AW-1:0]      = io_base[i];
            rdata[16 +: IO_SIZE_W] = io_size[i];
         end
      end
      for (int j = 0; j < MEM_WINS; j++) begin
         if (addr == A_MEM_WIN + 8'(8 * j))
            rdata = mem_base[j];
         if (addr == A_MEM_WIN + 8'(8 * j + 4))
            rdata[MEM_SIZE_W-1:0] = mem_size[j];
      end
   end
endmodule

// File: rtl/hwd_range.sv
module hwd_range #(
   parameter int AW = 16,
   parameter int SW = 8
) (
   input  logic          en,
   input  logic [AW-1:0] base,
   input  logic [SW-1:0] size,
   input  logic [AW-1:0] addr,
   output logic          hit
);
   logic [AW:0] last;

   assign last = {1'b0, base} + {{(AW + 1 - SW){1'b0}}, size};
   assign hit  = en && (addr >= base) && ({1'b0, addr} <= last);
endmodule

// File: rtl/hwd_fixed.sv
module hwd_fixed
   import hwd_pkg::*;
(
   input  logic                 is_io,
   input  logic [NUM_FIXED-1:0] en,
   input  logic [IO_AW-1:0]     port,
   output logic [NUM_FIXED-1:0] hits
);
   always_comb begin
      hits          = '0;
      hits[FIX_P80] = is_io && en[FIX_P80] && (port == 16'h0080);
      hits[FIX_KBD] = is_io && en[FIX_KBD] && ((port == 16'h0060) || (port == 16'h0064));
      hits[FIX_SIO] = is_io && en[FIX_SIO] && ((port == 16'h002E) || (port == 16'h002F));
   end
endmodule

// File: rtl/haddr_window_decoder.sv
module haddr_window_decoder
   import hwd_pkg::*;
#(
   parameter int IO_WINS    = 4,
   parameter int MEM_WINS   = 4,
   parameter int IO_SIZE_W  = 8,
   parameter int MEM_SIZE_W = 16,
   parameter int IDXW       = $clog2(NUM_FIXED + IO_WINS + MEM_WINS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [7:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic            lk_is_mem,
   input  logic [31:0]     lk_addr,
   output logic            lk_hit,
   output logic [IDXW-1:0] lk_index,
   output logic            lk_sub,
   output logic [1:0]      lk_sub_tgt
);
   localparam int TOTAL = NUM_FIXED + IO_WINS + MEM_WINS;

   if (IO_WINS < 1 || IO_WINS > 8)
      $error("IO_WINS must be 1..8");
   if (MEM_WINS < 1 || MEM_WINS > 8)
      $error("MEM_WINS must be 1..8");
   if (IO_SIZE_W < 1 || IO_SIZE_W > 16)
      $error("IO_SIZE_W must be 1..16");
   if (MEM_SIZE_W < 1 || MEM_SIZE_W > 32)
      $error("MEM_SIZE_W must be 1..32");
   if ((2 ** IDXW) < TOTAL)
      $error("IDXW too narrow for the decode count");

   logic [NUM_FIXED-1:0]                fixed_en;
   logic [IO_WINS-1:0]                  io_en;
   logic [MEM_WINS-1:0]                 mem_en;
   logic [IO_WINS-1:0][IO_AW-1:0]       io_base;
   logic [IO_WINS-1:0][IO_SIZE_W-1:0]   io_size;
   logic [MEM_WINS-1:0][MEM_AW-1:0]     mem_base;
   logic [MEM_WINS-1:0][MEM_SIZE_W-1:0] mem_size;
   logic                                bm_en;
   logic                                sub_en;
   logic [1:0]                          sub_tgt;

   hwd_regs #(
      .IO_WINS(IO_WINS), .MEM_WINS(MEM_WINS),
      .IO_SIZE_W(IO_SIZE_W), .MEM_SIZE_W(MEM_SIZE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .fixed_en(fixed_en), .io_en(io_en), .mem_en(mem_en),
      .io_base(io_base), .io_size(io_size),
      .mem_base(mem_base), .mem_size(mem_size),
      .bm_en(bm_en), .sub_en(sub_en), .sub_tgt(sub_tgt)
   );

   logic [NUM_FIXED-1:0] fix_hits;
   logic [IO_WINS-1:0]   io_hits;
   logic [MEM_WINS-1:0]  mem_hits;
   logic [TOTAL-1:0]     all_hits;

   hwd_fixed u_fixed (
      .is_io(~lk_is_mem), .en(fixed_en), .port(lk_addr[IO_AW-1:0]), .hits(fix_hits)
   );

   for (genvar gi = 0; gi < IO_WINS; gi++) begin : g_io
      hwd_range #(.AW(IO_AW), .SW(IO_SIZE_W)) u_rng (
         .en(io_en[gi] & ~lk_is_mem), .base(io_base[gi]), .size(io_size[gi]),
         .addr(lk_addr[IO_AW-1:0]), .hit(io_hits[gi])
      );
   end

   for (genvar gj = 0; gj < MEM_WINS; gj++) begin : g_mem
      hwd_range #(.AW(MEM_AW), .SW(MEM_SIZE_W)) u_rng (
         .en(mem_en[gj] & lk_is_mem), .base(mem_base[gj]), .size(mem_size[gj]),
         .addr(lk_addr), .hit(mem_hits[gj])
      );
   end

   // bit order sets priority: fixed, then I/O windows, then memory windows
   assign all_hits = {mem_hits, io_hits, fix_hits};

   logic            found;
   logic [IDXW-1:0] sel;

   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int k = TOTAL - 1; k >= 0; k--) begin
         if (all_hits[k]) begin
            found = 1'b1;
            sel   = IDXW'(k);
         end
      end
   end

   assign lk_hit     = bm_en & found;
   assign lk_index   = lk_hit ? sel : '0;
   assign lk_sub     = bm_en & sub_en & ~found;
   assign lk_sub_tgt = lk_sub ? sub_tgt : 2'd0;
endmodule

// File: rtl/hwd_checker.sv
module hwd_checker #(
   parameter int IDXW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_we,
   input logic [7:0]      reg_addr,
   input logic [31:0]     reg_wdata,
   input logic            lk_hit,
   input logic [IDXW-1:0] lk_index,
   input logic            lk_sub,
   input logic [1:0]      lk_sub_tgt,
   input logic            bm_en,
   input logic            sub_en,
   input logic [1:0]      sub_tgt
);
   p_bm_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bm_en |-> (!lk_hit && !lk_sub));

   p_claim_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> !lk_sub);

   p_sub_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_sub |-> (sub_en && lk_sub_tgt == sub_tgt));

   p_tgt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_sub |-> (lk_sub_tgt == 2'd0));

   p_miss_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_index == '0));

   p_enable_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 8'h00 && reg_wdata == 32'h0) |=> !lk_hit);
endmodule

bind haddr_window_decoder hwd_checker #(.IDXW(IDXW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .lk_hit(lk_hit), .lk_index(lk_index),
   .lk_sub(lk_sub), .lk_sub_tgt(lk_sub_tgt),
   .bm_en(bm_en), .sub_en(sub_en), .sub_tgt(sub_tgt)
);

// File: tb/sim_haddr_window_decoder.sv
`timescale 1ns/1ps
module sim_haddr_window_decoder;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        lk_is_mem = 1'b0;
   logic [31:0] lk_addr = 32'h0;
   logic        lk_hit;
   logic [3:0]  lk_index;
   logic        lk_sub;
   logic [1:0]  lk_sub_tgt;

   int checks = 0;
   int failures = 0;

   // bench-side copies of what has been programmed
   logic [31:0] sh_en = 0;
   logic        sh_bm = 0, sh_sub = 0;
   logic [1:0]  sh_tgt = 0;
   logic [15:0] sh_iob [4];
   logic [7:0]  sh_ios [4];
   logic [31:0] sh_mb  [4];
   logic [15:0] sh_ms  [4];

   always #(CLK_PERIOD / 2) clk = ~clk;

   haddr_window_decoder u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_is_mem(lk_is_mem),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_index(lk_index),
      .lk_sub(lk_sub), .lk_sub_tgt(lk_sub_tgt)
   );

   // packed as {hit, sub, tgt[1:0], index[3:0]}
   function automatic logic [7:0] model(input logic is_mem, input logic [31:0] a);
      logic       m = 1'b0;
      logic [3:0] idx = 4'd0;
      logic       h, s;
      if (!is_mem) begin
         if (sh_en[0] && a[15:0] == 16'h0080) begin m = 1; idx = 0; end
         else if (sh_en[1] && (a[15:0] == 16'h0060 || a[15:0] == 16'h0064)) begin m = 1; idx = 1; end
         else if (sh_en[2] && (a[15:0] == 16'h002E || a[15:0] == 16'h002F)) begin m = 1; idx = 2; end
         else begin
            for (int i = 0; i < 4; i++)
               if (!m && sh_en[8+i] && 32'(a[15:0]) >= 32'(sh_iob[i]) &&
                   32'(a[15:0]) <= 32'(sh_iob[i]) + 32'(sh_ios[i])) begin
                  m = 1; idx = 4'(3 + i);
               end
         end
      end else begin
         for (int j = 0; j < 4; j++)
            if (!m && sh_en[16+j] && 64'(a) >= 64'(sh_mb[j]) &&
                64'(a) <= 64'(sh_mb[j]) + 64'(sh_ms[j])) begin
               m = 1; idx = 4'(7 + j);
            end
      end
      h = sh_bm && m;
      s = sh_bm && sh_sub && !m;
      return {h, s, s ? sh_tgt : 2'd0, h ? idx : 4'd0};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
      if (a == 8'h00) sh_en = d & 32'h000F0F07;
      if (a == 8'h04) begin sh_bm = d[1]; sh_sub = d[2]; sh_tgt = d[4:3]; end
      for (int i = 0; i < 4; i++)
         if (a == 8'h40 + 8'(4*i)) begin sh_iob[i] = d[15:0]; sh_ios[i] = d[23:16]; end
      for (int j = 0; j < 4; j++) begin
         if (a == 8'h80 + 8'(8*j)) sh_mb[j] = d;
         if (a == 8'h84 + 8'(8*j)) sh_ms[j] = d[15:0];
      end
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, $sformatf("read 0x%h", a), reg_rdata, exp);
   endtask

   function automatic logic [31:0] got();
      return {24'h0, lk_hit, lk_sub, lk_sub_tgt, lk_index};
   endfunction

   task automatic probe(input string req, input logic is_mem, input logic [31:0] a,
                        input logic [7:0] exp);
      lk_is_mem = is_mem; lk_addr = a;
      #1;
      chk(req, $sformatf("lookup mem=%0d addr=%h", is_mem, a), got(), {24'h0, exp});
   endtask

   task automatic sweep_io(input string req);
      int errs = 0;
      logic [31:0] fa = 0, fact = 0, fexp = 0;
      for (int p = 0; p < 65536; p++) begin
         lk_is_mem = 0;
         lk_addr = {16'hABCD, 16'(p)};
         #1;
         if (got() !== {24'h0, model(1'b0, lk_addr)}) begin
            if (errs == 0) begin fa = lk_addr; fact = got(); fexp = {24'h0, model(1'b0, lk_addr)}; end
            errs++;
         end
      end
      checks++;
      if (errs != 0) begin
         failures++;
         $display("FAIL %s io sweep first port=%h actual=%h expected=%h (%0d mismatches)",
                  req, fa, fact, fexp, errs);
      end
   endtask

   task automatic sweep_mem(input string req);
      int errs = 0;
      logic [31:0] pts [6];
      logic [31:0] fa = 0, fact = 0, fexp = 0;
      for (int j = 0; j < 4; j++) begin
         pts[0] = sh_mb[j] - 1;
         pts[1] = sh_mb[j];
         pts[2] = sh_mb[j] + 32'(sh_ms[j]);
         pts[3] = sh_mb[j] + 32'(sh_ms[j]) + 1;
         pts[4] = 32'h0000_0080;
         pts[5] = 32'hFFFF_FFFF;
         for (int k = 0; k < 6; k++) begin
            lk_is_mem = 1; lk_addr = pts[k];
            #1;
            if (got() !== {24'h0, model(1'b1, lk_addr)}) begin
               if (errs == 0) begin fa = lk_addr; fact = got(); fexp = {24'h0, model(1'b1, lk_addr)}; end
               errs++;
            end
         end
      end
      checks++;
      if (errs != 0) begin
         failures++;
         $display("FAIL %s mem edges first addr=%h actual=%h expected=%h (%0d mismatches)",
                  req, fa, fact, fexp, errs);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin sh_iob[i] = 0; sh_ios[i] = 0; sh_mb[i] = 0; sh_ms[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      rd_chk("R1", 8'h00, 32'h0);
      rd_chk("R1", 8'h04, 32'h0);
      rd_chk("R1", 8'h40, 32'h0);
      probe("R1", 1'b0, 32'h0000_0080, 8'h00);

      // R2: field masks on read-back
      wr(8'h00, 32'hFFFF_FFFF);
      rd_chk("R2", 8'h00, 32'h000F_0F07);
      wr(8'h04, 32'hFFFF_FFFF);
      rd_chk("R2", 8'h04, 32'h0000_001E);
      wr(8'h4C, 32'hFFFF_FFFF);
      rd_chk("R2", 8'h4C, 32'h00FF_FFFF);
      wr(8'h9C, 32'hFFFF_FFFF);
      rd_chk("R2", 8'h9C, 32'h0000_FFFF);
      wr(8'h98, 32'h1234_5678);
      rd_chk("R2", 8'h98, 32'h1234_5678);

      // main configuration with deliberate overlaps
      wr(8'h04, 32'h0000_0002);
      wr(8'h40, {8'h00, 8'h0F, 16'h0100});
      wr(8'h44, {8'h00, 8'h1F, 16'h0108});
      wr(8'h48, {8'h00, 8'hFF, 16'hFFF0});
      wr(8'h4C, {8'h00, 8'h03, 16'h0060});
      wr(8'h80, 32'hFFFF_FF00); wr(8'h84, 32'h0000_FFFF);
      wr(8'h88, 32'h1000_0000); wr(8'h8C, 32'h0000_0000);
      wr(8'h90, 32'h2000_0000); wr(8'h94, 32'h0000_0FFF);
      wr(8'h98, 32'h1000_0000); wr(8'h9C, 32'h0000_0010);
      wr(8'h00, 32'h000B_0F07);

      probe("R5", 1'b0, 32'h0000_0080, 8'h80);
      probe("R6", 1'b0, 32'h0000_0060, 8'h81);
      probe("R5", 1'b0, 32'h0000_002F, 8'h82);
      probe("R6", 1'b0, 32'h0000_0061, 8'h86);
      probe("R6", 1'b0, 32'h0000_0108, 8'h83);
      probe("R3", 1'b0, 32'h0000_0110, 8'h84);
      probe("R3", 1'b0, 32'h0000_0128, 8'h00);
      probe("R7", 1'b0, 32'h0000_FFFF, 8'h85);
      probe("R7", 1'b0, 32'h0000_0000, 8'h00);
      probe("R3", 1'b0, 32'hFFFF_0110, 8'h84);
      probe("R7", 1'b1, 32'hFFFF_FFFF, 8'h87);
      probe("R7", 1'b1, 32'h0000_00EF, 8'h00);
      probe("R6", 1'b1, 32'h1000_0000, 8'h88);
      probe("R4", 1'b1, 32'h1000_0001, 8'h8A);
      probe("R4", 1'b1, 32'h2000_0000, 8'h00);
      probe("R11", 1'b1, 32'h0000_0080, 8'h00);
      probe("R11", 1'b0, 32'h1000_0000, 8'h00);
      sweep_io("R3");
      sweep_mem("R4");

      // R5: kbd pair disabled, overlapping window takes 0x60
      wr(8'h00, 32'h000B_0F05);
      probe("R5", 1'b0, 32'h0000_0060, 8'h86);
      probe("R5", 1'b0, 32'h0000_0064, 8'h00);
      sweep_io("R5");

      // R10: fallback claim with target 2
      wr(8'h04, 32'h0000_0016);
      probe("R10", 1'b0, 32'h0000_5000, 8'h60);
      probe("R10", 1'b0, 32'h0000_0080, 8'h80);
      probe("R10", 1'b1, 32'h3000_0000, 8'h60);
      sweep_io("R10");

      // R9: bus-master gate off
      wr(8'h04, 32'h0000_0014);
      probe("R9", 1'b0, 32'h0000_0080, 8'h00);
      probe("R9", 1'b0, 32'h0000_5000, 8'h00);
      sweep_io("R9");

      // R8: clearing the enable register
      wr(8'h04, 32'h0000_0002);
      wr(8'h00, 32'h0000_0000);
      probe("R8", 1'b0, 32'h0000_0080, 8'h00);
      probe("R8", 1'b0, 32'h0000_0100, 8'h00);
      probe("R8", 1'b1, 32'hFFFF_FFFF, 8'h00);
      sweep_io("R8");
      sweep_mem("R8");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule